// File: doc/BRIEF.md
# Dual-View Instruction Store

This block holds a program as an array of 32-bit words and presents it in two ways. A Harvard-style fetch unit sees a read-only sequence of 16-bit instructions, indexed by a 16-bit program counter. A system bus sees the same storage as byte-addressed memory that it may only access with full 32-bit word transfers. The bus uses this view to load a program and to inspect it.

The fetch port turns a program counter value into a word index and a half-word select. Instruction n therefore lives at byte offset 2n of the bus region. Both ports share one single-ported array. When both ask for it in the same cycle, the bus is served and the fetch unit is told to stall and retry. Bus transfers that are not full, aligned words are refused with an error and leave storage untouched. Each side gets its response one cycle after it is granted the array.

Top module: `imem_dualview`

## Requirements
- R1: While reset is held, and in the first cycle after it is released with no request made, `fetch_valid`, `bus_ready` and `bus_err` are 0.
- R2: A bus transfer with `bus_size` = 2 (word) and `bus_addr[1:0]` = 0 addresses word `bus_addr >> 2`. A write stores `bus_wdata` there. A read returns that word on `bus_rdata`. In both cases `bus_ready` is 1, with `bus_err` = 0, in the cycle after `bus_sel`.
- R3: A granted fetch raises `fetch_valid` in the next cycle, with `fetch_instr` holding one half of word `fetch_pc >> 1`. `fetch_pc[0]` = 0 selects bits 15:0 and `fetch_pc[0]` = 1 selects bits 31:16.
- R4: Instruction index n is the half-word at byte offset 2n of the bus view. The word written at byte address 4k supplies instructions 2k and 2k+1.
- R5: When `bus_sel` and `fetch_req` are both high in a cycle, `fetch_stall` is 1 in that cycle and the bus transfer is performed. `fetch_valid` is 0 in the next cycle.
- R6: A bus transfer whose `bus_size` is not 2 (0 = byte, 1 = half, 3 = reserved) gets `bus_ready` = 1 and `bus_err` = 1 in the next cycle, with `bus_rdata` = 0. Storage is not modified.
- R7: A bus transfer with `bus_addr[1:0]` not 0 gets `bus_ready` = 1 and `bus_err` = 1 in the next cycle, with `bus_rdata` = 0. Storage is not modified.
- R8: A fetch in a cycle without `bus_sel` is never stalled. Fetches in consecutive cycles each produce valid data in the following cycle.
- R9: Program counter bits above the implemented instruction range are ignored. With 2^WORD_AW words, `fetch_pc` and `fetch_pc + 2^(WORD_AW+1)` return the same instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_req | input | 1 | Fetch unit requests an instruction |
| fetch_pc | input | 16 | Instruction index (program counter) |
| fetch_stall | output | 1 | Fetch not granted this cycle; retry |
| fetch_valid | output | 1 | `fetch_instr` holds a fetched instruction |
| fetch_instr | output | 16 | Fetched instruction |
| bus_sel | input | 1 | Bus transfer request, one cycle per transfer |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | Transfer size: 0 byte, 1 half, 2 word, 3 reserved |
| bus_addr | input | WORD_AW+2 | Byte address within the region |
| bus_wdata | input | 32 | Write data |
| bus_ready | output | 1 | Response for the previous cycle's transfer |
| bus_err | output | 1 | Transfer refused |
| bus_rdata | output | 32 | Read data (0 on writes and errors) |

## Verification
The hardest case to reach from the ports is a collision: a bus transfer and a fetch must arrive in the same clock cycle, and the stall, the loss of fetch data and the bus response must all be observed together. The stimulus raises `bus_sel` and `fetch_req` on the same falling edge. It samples `fetch_stall` before the rising edge and the responses after it. It then holds the fetch alone for one more cycle to show that the retried fetch is served. The refused-transfer cases are checked by reading the targeted word back through a legal transfer afterwards.

// File: rtl/imem_pkg.sv
package imem_pkg;
    localparam int INSTR_W = 16;
    localparam int WORD_W  = 32;
    localparam int PC_W    = 16;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } bus_size_e;

    typedef struct packed {
        logic ready;
        logic is_read;
        logic err;
    } bus_rsp_t;

    function automatic logic [INSTR_W-1:0] pick_half(input logic [WORD_W-1:0] w,
                                                     input logic upper);
        return upper ? w[WORD_W-1:INSTR_W] : w[INSTR_W-1:0];
    endfunction
endpackage

// File: rtl/imem_store.sv
module imem_store
    import imem_pkg::*;
#(
    parameter int WORD_AW = 8
) (
    input  logic               clk,
    input  logic               we,
    input  logic [WORD_AW-1:0] addr,
    input  logic [WORD_W-1:0]  wdata,
    output logic [WORD_W-1:0]  rdata
);
    localparam int DEPTH = 1 << WORD_AW;

    logic [WORD_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end
        rdata <= mem[addr];
    end
endmodule

// File: rtl/imem_bus_port.sv
module imem_bus_port
    import imem_pkg::*;
#(
    parameter int WORD_AW = 8,
    localparam int BYTE_AW = WORD_AW + 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_sel,
    input  logic               bus_we,
    input  logic [1:0]         bus_size,
    input  logic [BYTE_AW-1:0] bus_addr,
    input  logic [WORD_W-1:0]  mem_rdata,
    output logic               acc_ok,
    output logic [WORD_AW-1:0] word_idx,
    output logic               bus_ready,
    output logic               bus_err,
    output logic [WORD_W-1:0]  bus_rdata
);
    bus_size_e size_e;
    bus_rsp_t  rsp_q;

    assign size_e   = bus_size_e'(bus_size);
    assign acc_ok   = (size_e == SZ_WORD) && (bus_addr[1:0] == 2'b00);
    assign word_idx = bus_addr[BYTE_AW-1:2];

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_q <= '0;
        end else begin
            rsp_q.ready   <= bus_sel;
            rsp_q.is_read <= bus_sel && !bus_we && acc_ok;
            rsp_q.err     <= bus_sel && !acc_ok;
        end
    end

    assign bus_ready = rsp_q.ready;
    assign bus_err   = rsp_q.err;
    assign bus_rdata = rsp_q.is_read ? mem_rdata : '0;

    // R6: a size other than word is refused on the next cycle
    a_r6_size_refused: assert property (@(posedge clk) disable iff (rst)
        bus_sel && bus_size != 2'd2 |=> bus_ready && bus_err);
    // R7: a misaligned byte address is refused on the next cycle
    a_r7_misaligned_refused: assert property (@(posedge clk) disable iff (rst)
        bus_sel && bus_addr[1:0] != 2'b00 |=> bus_ready && bus_err && bus_rdata == '0);
    // R2: each transfer gets exactly one response in the next cycle
    a_r2_one_response: assert property (@(posedge clk) disable iff (rst)
        !bus_sel |=> !bus_ready);
endmodule

// File: rtl/imem_fetch_port.sv
module imem_fetch_port
    import imem_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               grant,
    input  logic               pc_lsb,
    input  logic [WORD_W-1:0]  mem_rdata,
    output logic               fetch_valid,
    output logic [INSTR_W-1:0] fetch_instr
);
    logic upper_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            fetch_valid <= 1'b0;
            upper_q     <= 1'b0;
        end else begin
            fetch_valid <= grant;
            if (grant) begin
                upper_q <= pc_lsb;
            end
        end
    end

    assign fetch_instr = fetch_valid ? pick_half(mem_rdata, upper_q) : '0;
endmodule

// File: rtl/imem_arbiter.sv
module imem_arbiter #(
    parameter int WORD_AW = 8
) (
    input  logic               bus_sel,
    input  logic               bus_we,
    input  logic               bus_ok,
    input  logic [WORD_AW-1:0] bus_idx,
    input  logic               fetch_req,
    input  logic [WORD_AW-1:0] fetch_idx,
    output logic               fetch_grant,
    output logic               fetch_stall,
    output logic               mem_we,
    output logic [WORD_AW-1:0] mem_addr
);
    always_comb begin
        fetch_grant = fetch_req && !bus_sel;
        fetch_stall = fetch_req && bus_sel;
        mem_we      = bus_sel && bus_we && bus_ok;
        mem_addr    = bus_sel ? bus_idx : fetch_idx;
    end
endmodule

// File: rtl/imem_dualview.sv
module imem_dualview
    import imem_pkg::*;
#(
    parameter int WORD_AW = 8,
    localparam int BYTE_AW = WORD_AW + 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               fetch_req,
    input  logic [15:0]        fetch_pc,
    output logic               fetch_stall,
    output logic               fetch_valid,
    output logic [15:0]        fetch_instr,
    input  logic               bus_sel,
    input  logic               bus_we,
    input  logic [1:0]         bus_size,
    input  logic [BYTE_AW-1:0] bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic               bus_ready,
    output logic               bus_err,
    output logic [31:0]        bus_rdata
);
    logic               acc_ok;
    logic [WORD_AW-1:0] bus_idx;
    logic [WORD_AW-1:0] fetch_idx;
    logic               fetch_grant;
    logic               mem_we;
    logic [WORD_AW-1:0] mem_addr;
    logic [WORD_W-1:0]  mem_rdata;

    assign fetch_idx = fetch_pc[WORD_AW:1];

    imem_arbiter #(.WORD_AW(WORD_AW)) u_arb (
        .bus_sel    (bus_sel),
        .bus_we     (bus_we),
        .bus_ok     (acc_ok),
        .bus_idx    (bus_idx),
        .fetch_req  (fetch_req),
        .fetch_idx  (fetch_idx),
        .fetch_grant(fetch_grant),
        .fetch_stall(fetch_stall),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr)
    );

    imem_store #(.WORD_AW(WORD_AW)) u_store (
        .clk  (clk),
        .we   (mem_we),
        .addr (mem_addr),
        .wdata(bus_wdata),
        .rdata(mem_rdata)
    );

    imem_bus_port #(.WORD_AW(WORD_AW)) u_bus (
        .clk      (clk),
        .rst      (rst),
        .bus_sel  (bus_sel),
        .bus_we   (bus_we),
        .bus_size (bus_size),
        .bus_addr (bus_addr),
        .mem_rdata(mem_rdata),
        .acc_ok   (acc_ok),
        .word_idx (bus_idx),
        .bus_ready(bus_ready),
        .bus_err  (bus_err),
        .bus_rdata(bus_rdata)
    );

    imem_fetch_port u_fetch (
        .clk        (clk),
        .rst        (rst),
        .grant      (fetch_grant),
        .pc_lsb     (fetch_pc[0]),
        .mem_rdata  (mem_rdata),
        .fetch_valid(fetch_valid),
        .fetch_instr(fetch_instr)
    );

    // R5: a stalled fetch yields no data in the next cycle
    a_r5_stall_no_data: assert property (@(posedge clk) disable iff (rst)
        fetch_stall |=> !fetch_valid);
    // R5: stall only ever accompanies a bus transfer
    a_r5_stall_needs_bus: assert property (@(posedge clk) disable iff (rst)
        fetch_stall |-> bus_sel);
    // R8: an uncontested fetch is served in the next cycle
    a_r8_fetch_served: assert property (@(posedge clk) disable iff (rst)
        fetch_req && !bus_sel |=> fetch_valid);
    // R1: no response without a request in the previous cycle
    a_r1_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
        !fetch_req |=> !fetch_valid);
endmodule

// File: tb/imem_dualview_test.sv
module imem_dualview_test;
    localparam int WORD_AW = 8;
    localparam int BYTE_AW = WORD_AW + 2;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               fetch_req = 1'b0;
    logic [15:0]        fetch_pc = '0;
    logic               fetch_stall;
    logic               fetch_valid;
    logic [15:0]        fetch_instr;
    logic               bus_sel = 1'b0;
    logic               bus_we = 1'b0;
    logic [1:0]         bus_size = 2'd2;
    logic [BYTE_AW-1:0] bus_addr = '0;
    logic [31:0]        bus_wdata = '0;
    logic               bus_ready;
    logic               bus_err;
    logic [31:0]        bus_rdata;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    imem_dualview #(.WORD_AW(WORD_AW)) uut (.*);

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_xfer(input bit we, input logic [1:0] sz, input logic [BYTE_AW-1:0] a,
                            input logic [31:0] wd, input bit exp_err,
                            input logic [31:0] exp_rd, input string req);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = we; bus_size = sz; bus_addr = a; bus_wdata = wd;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0; bus_size = 2'd2;
        check(bus_ready == 1'b1, req, {31'd0, bus_ready}, 32'd1);
        check(bus_err == exp_err, req, {31'd0, bus_err}, {31'd0, exp_err});
        if (!we || exp_err) check(bus_rdata == exp_rd, req, bus_rdata, exp_rd);
    endtask

    task automatic fetch(input logic [15:0] pc, input logic [15:0] exp, input string req);
        @(negedge clk);
        fetch_req = 1'b1; fetch_pc = pc;
        #1 check(fetch_stall == 1'b0, req, {31'd0, fetch_stall}, 32'd0);
        @(negedge clk);
        fetch_req = 1'b0;
        check(fetch_valid == 1'b1, req, {31'd0, fetch_valid}, 32'd1);
        check(fetch_instr == exp, req, {16'd0, fetch_instr}, {16'd0, exp});
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(fetch_valid == 1'b0 && bus_ready == 1'b0 && bus_err == 1'b0, "R1 reset held",
              {29'd0, fetch_valid, bus_ready, bus_err}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check(fetch_valid == 1'b0 && bus_ready == 1'b0 && bus_err == 1'b0, "R1 after reset",
              {29'd0, fetch_valid, bus_ready, bus_err}, 32'd0);
    endtask

    task automatic t_load();
        bus_xfer(1'b1, 2'd2, 'h000, 32'hBEEF_1234, 1'b0, 32'd0, "R2 write w0");
        bus_xfer(1'b1, 2'd2, 'h004, 32'hCAFE_5678, 1'b0, 32'd0, "R2 write w1");
        bus_xfer(1'b1, 2'd2, 'h3FC, 32'hA5A5_0F0F, 1'b0, 32'd0, "R2 write last");
        bus_xfer(1'b0, 2'd2, 'h000, 32'd0, 1'b0, 32'hBEEF_1234, "R2 read w0");
        bus_xfer(1'b0, 2'd2, 'h004, 32'd0, 1'b0, 32'hCAFE_5678, "R2 read w1");
        bus_xfer(1'b0, 2'd2, 'h3FC, 32'd0, 1'b0, 32'hA5A5_0F0F, "R2 read last");
    endtask

    task automatic t_fetch_halves();
        fetch(16'd0, 16'h1234, "R3 low half pc0");
        fetch(16'd1, 16'hBEEF, "R3 high half pc1");
        fetch(16'd2, 16'h5678, "R4 instr 2 at byte 4");
        fetch(16'd3, 16'hCAFE, "R4 instr 3 at byte 6");
        fetch(16'd511, 16'hA5A5, "R3 last instruction");
        fetch(16'd510, 16'h0F0F, "R3 second last instruction");
        fetch(16'h0203, 16'hCAFE, "R9 upper pc bits ignored");
        fetch(16'hFE00, 16'h1234, "R9 top pc bits ignored");
    endtask

    task automatic t_refused();
        bus_xfer(1'b1, 2'd0, 'h000, 32'h1111_1111, 1'b1, 32'd0, "R6 byte write");
        bus_xfer(1'b1, 2'd1, 'h000, 32'h2222_2222, 1'b1, 32'd0, "R6 half write");
        bus_xfer(1'b1, 2'd3, 'h000, 32'h3333_3333, 1'b1, 32'd0, "R6 reserved write");
        bus_xfer(1'b0, 2'd1, 'h004, 32'd0, 1'b1, 32'd0, "R6 half read");
        bus_xfer(1'b0, 2'd2, 'h000, 32'd0, 1'b0, 32'hBEEF_1234, "R6 storage unchanged");
        bus_xfer(1'b1, 2'd2, 'h006, 32'h4444_4444, 1'b1, 32'd0, "R7 misaligned write");
        bus_xfer(1'b0, 2'd2, 'h002, 32'd0, 1'b1, 32'd0, "R7 misaligned read");
        bus_xfer(1'b0, 2'd2, 'h004, 32'd0, 1'b0, 32'hCAFE_5678, "R7 storage unchanged");
    endtask

    task automatic t_collision();
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_size = 2'd2; bus_addr = 'h004;
        fetch_req = 1'b1; fetch_pc = 16'd0;
        #1 check(fetch_stall == 1'b1, "R5 stall on collision", {31'd0, fetch_stall}, 32'd1);
        @(negedge clk);
        bus_sel = 1'b0;
        check(fetch_valid == 1'b0, "R5 no fetch data", {31'd0, fetch_valid}, 32'd0);
        check(bus_ready == 1'b1 && bus_err == 1'b0, "R5 bus served",
              {30'd0, bus_ready, bus_err}, 32'd2);
        check(bus_rdata == 32'hCAFE_5678, "R5 bus data", bus_rdata, 32'hCAFE_5678);
        #1 check(fetch_stall == 1'b0, "R5 retry not stalled", {31'd0, fetch_stall}, 32'd0);
        @(negedge clk);
        fetch_req = 1'b0;
        check(fetch_valid == 1'b1 && fetch_instr == 16'h1234, "R5 retried fetch",
              {15'd0, fetch_valid, fetch_instr}, {15'd0, 1'b1, 16'h1234});
    endtask

    task automatic t_back_to_back();
        @(negedge clk);
        fetch_req = 1'b1; fetch_pc = 16'd1;
        @(negedge clk);
        check(fetch_valid && fetch_instr == 16'hBEEF, "R8 first of pair",
              {16'd0, fetch_instr}, 32'h0000_BEEF);
        fetch_pc = 16'd2;
        #1 check(fetch_stall == 1'b0, "R8 no stall", {31'd0, fetch_stall}, 32'd0);
        @(negedge clk);
        fetch_req = 1'b0;
        check(fetch_valid && fetch_instr == 16'h5678, "R8 second of pair",
              {16'd0, fetch_instr}, 32'h0000_5678);
        @(negedge clk);
        check(fetch_valid == 1'b0, "R8 idle after pair", {31'd0, fetch_valid}, 32'd0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (2) @(posedge clk);
        t_reset();
        t_load();
        t_fetch_halves();
        t_refused();
        t_collision();
        t_back_to_back();
        finish_run();
    end
endmodule